// File: doc/BRIEF.md
# Per-Subcarrier Complex Channel Equalizer

This block equalizes a stream of frequency-domain samples, one subcarrier per valid cycle. With each sample it receives the channel estimate for the same subcarrier and a noise-variance value. It returns the sample divided by the channel response as a complex fixed-point number. Each subcarrier is handled on its own. Consecutive valid cycles may carry any subcarrier of any symbol, so a full symbol is simply streamed through one index after another.

The numerator is the data sample multiplied by the complex conjugate of the estimate. A build-time mode parameter picks the denominator. In zero-forcing mode it is the squared magnitude of the estimate. In MMSE mode it is that squared magnitude plus the noise variance. The quotient comes from two identical pipelined restoring dividers, one for the real part and one for the imaginary part. Each divider resolves one quotient bit per stage. The result is truncated toward zero and clamped to the signed output range. A zero denominator forces a zero output and raises a flag alongside the affected result. Latency is fixed, and a new sample can be accepted in every cycle.

Top module: `freq_equalizer`

## Requirements
- R1: While reset is asserted, and until the first result emerges, `out_valid` and `div_zero` are 0. `out_re` and `out_im` read 0 after reset.
- R2: In zero-forcing mode (MODE = EQ_ZF), the numerators are (d_re*h_re + d_im*h_im) for the real part and (d_im*h_re - d_re*h_im) for the imaginary part. The denominator is h_re^2 + h_im^2. Each output is trunc_toward_zero(numerator * 2^FW / denominator), so inputs and outputs both carry FW fraction bits.
- R3: In zero-forcing mode, `noise_var` has no effect on any output.
- R4: In MMSE mode (MODE = EQ_MMSE), the denominator is h_re^2 + h_im^2 + noise_var * 2^FW. `noise_var` is an unsigned value with FW fraction bits. Numerator and quotient scaling are as in R2.
- R5: Every accepted sample produces exactly one result, exactly LAT = DW + 3 cycles after it is presented, in input order. Samples may be presented back to back or with gaps. `out_valid` is never high without a matching input.
- R6: A quotient above 2^(DW-1)-1 saturates to 2^(DW-1)-1. A quotient below -2^(DW-1) saturates to -2^(DW-1).
- R7: When the denominator is zero, both outputs are 0 and `div_zero` is 1 in the same cycle as `out_valid`. `div_zero` is never 1 without `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Marks a subcarrier sample on the inputs |
| data_re | input | DW | Data sample, real part, signed, FW fraction bits |
| data_im | input | DW | Data sample, imaginary part |
| est_re | input | DW | Channel estimate, real part, signed, FW fraction bits |
| est_im | input | DW | Channel estimate, imaginary part |
| noise_var | input | DW | Noise variance, unsigned, FW fraction bits (MMSE only) |
| out_valid | output | 1 | Marks an equalized result |
| out_re | output | DW | Equalized sample, real part |
| out_im | output | DW | Equalized sample, imaginary part |
| div_zero | output | 1 | Denominator was zero for this result |

## Verification
The hardest cases to reach from the ports are a zero denominator, which in MMSE mode needs both a zero estimate and a zero noise variance, and quotients that exceed the divider's own quotient width and so rely on the overflow pre-check. The bench therefore adds a dense sweep over very small estimates (every pair in -3..3) to a coarse sweep across the full estimate range, and reuses data patterns at the signed extremes. The noise variance follows a pattern that forces zero on a fixed share of samples. A zero-forcing instance and an MMSE instance receive the identical stream, with idle gaps inserted, and every result is checked for value and arrival cycle.

// File: rtl/eq_pkg.sv
`timescale 1ns/1ps
package eq_pkg;

  // Denominator choice of the equalizer datapath.
  typedef enum logic {
    EQ_ZF   = 1'b0,
    EQ_MMSE = 1'b1
  } eq_mode_e;

endpackage

// File: rtl/eq_rst_sync.sv
`timescale 1ns/1ps
module eq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/eq_valid_pipe.sv
`timescale 1ns/1ps
module eq_valid_pipe #(
  parameter int LAT = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vin,
  output logic [LAT:0] vld
);
  logic [LAT:1] vld_q;
  logic [LAT:1] vld_d;

  always_comb begin
    vld_d = {vld_q[LAT-1:1], vin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign vld = {vld_q, vin};
endmodule

// File: rtl/eq_front.sv
`timescale 1ns/1ps
module eq_front
  import eq_pkg::*;
#(
  parameter int       DW   = 16,
  parameter int       FW   = 8,
  parameter eq_mode_e MODE = EQ_MMSE,
  localparam int NUMW = 2*DW + 1,
  localparam int DENW = 2*DW + 1,
  localparam int QW   = DW,
  localparam int WW   = DENW + QW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en1,
  input  logic                 en2,
  input  logic signed [DW-1:0] data_re,
  input  logic signed [DW-1:0] data_im,
  input  logic signed [DW-1:0] est_re,
  input  logic signed [DW-1:0] est_im,
  input  logic        [DW-1:0] noise_var,
  output logic        [WW-1:0] rem_re,
  output logic        [WW-1:0] rem_im,
  output logic        [WW-1:0] den_w,
  output logic                 neg_re,
  output logic                 neg_im,
  output logic                 ovf_re,
  output logic                 ovf_im,
  output logic                 den_zero
);
  // ---------------- stage 1: conjugate products and |h|^2 ----------------
  logic signed [NUMW-1:0] dr, di, hr, hi;
  logic signed [NUMW-1:0] nre_d, nim_d, sq;
  logic        [DENW-1:0] nv_term;
  logic        [DENW-1:0] den_d;
  logic signed [NUMW-1:0] nre_q, nim_q;
  logic        [DENW-1:0] den_q;

  generate
    if (MODE == EQ_MMSE) begin : g_mmse
      assign nv_term = DENW'(noise_var) << FW;
    end else begin : g_zf
      logic unused_nv;
      assign unused_nv = ^noise_var;
      assign nv_term   = '0;
    end
  endgenerate

  always_comb begin
    dr    = NUMW'(data_re);
    di    = NUMW'(data_im);
    hr    = NUMW'(est_re);
    hi    = NUMW'(est_im);
    nre_d = dr * hr + di * hi;
    nim_d = di * hr - dr * hi;
    sq    = hr * hr + hi * hi;
    den_d = DENW'(unsigned'(sq)) + nv_term;
  end

  always_ff @(posedge clk) begin
    if (en1) begin
      nre_q <= nre_d;
      nim_q <= nim_d;
      den_q <= den_d;
    end
  end

  // ---------------- stage 2: magnitudes, scaling, range pre-check ----------------
  logic signed [NUMW-1:0] abs_re, abs_im;
  logic        [WW-1:0]   rre_d, rim_d, den_wd;
  logic                   nre_neg_d, nim_neg_d, ore_d, oim_d, zero_d;

  always_comb begin
    nre_neg_d = nre_q[NUMW-1];
    nim_neg_d = nim_q[NUMW-1];
    abs_re    = nre_neg_d ? -nre_q : nre_q;
    abs_im    = nim_neg_d ? -nim_q : nim_q;
    rre_d     = WW'(unsigned'(abs_re)) << FW;
    rim_d     = WW'(unsigned'(abs_im)) << FW;
    den_wd    = WW'(den_q);
    // quotient would need more than QW bits
    ore_d     = (rre_d >> QW) >= den_wd;
    oim_d     = (rim_d >> QW) >= den_wd;
    zero_d    = (den_q == '0);
  end

  always_ff @(posedge clk) begin
    if (en2) begin
      rem_re   <= rre_d;
      rem_im   <= rim_d;
      den_w    <= den_wd;
      neg_re   <= nre_neg_d;
      neg_im   <= nim_neg_d;
      ovf_re   <= ore_d;
      ovf_im   <= oim_d;
      den_zero <= zero_d;
    end
  end

  // R7: an all-zero estimate (and zero variance when it counts) gives a zero denominator
  a_r7_zero_estimate: assert property (@(posedge clk) disable iff (!rst_n)
    (en1 && est_re == '0 && est_im == '0 && (MODE == EQ_ZF || noise_var == '0))
      |=> (den_q == '0));

  generate
    if (MODE == EQ_MMSE) begin : g_chk_mmse
      // R4: the denominator never falls below the scaled noise variance
      a_r4_den_floor: assert property (@(posedge clk) disable iff (!rst_n)
        en1 |=> (den_q >= (DENW'($past(noise_var)) << FW)));
    end
  endgenerate
endmodule

// File: rtl/eq_div_stage.sv
`timescale 1ns/1ps
module eq_div_stage #(
  parameter int WW  = 49,
  parameter int QW  = 16,
  parameter int BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [WW-1:0] rem_i,
  input  logic [WW-1:0] den_i,
  input  logic [QW-1:0] q_i,
  input  logic          neg_i,
  input  logic          ovf_i,
  input  logic          zero_i,
  output logic [WW-1:0] rem_o,
  output logic [WW-1:0] den_o,
  output logic [QW-1:0] q_o,
  output logic          neg_o,
  output logic          ovf_o,
  output logic          zero_o
);
  logic [WW-1:0] trial;
  logic          fits;
  logic [WW-1:0] rem_d;
  logic [QW-1:0] q_d;

  always_comb begin
    trial = den_i << BIT;
    fits  = (rem_i >= trial);
    rem_d = fits ? (rem_i - trial) : rem_i;
    q_d   = q_i | (fits ? (QW'(1) << BIT) : '0);
  end

  always_ff @(posedge clk) begin
    if (en) begin
      rem_o  <= rem_d;
      den_o  <= den_i;
      q_o    <= q_d;
      neg_o  <= neg_i;
      ovf_o  <= ovf_i;
      zero_o <= zero_i;
    end
  end

  // R2: after resolving this bit, the remainder is below the shifted divisor
  a_r2_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !ovf_o && !zero_o) |-> (rem_o < (den_o << BIT)));
endmodule

// File: rtl/eq_divider.sv
`timescale 1ns/1ps
module eq_divider #(
  parameter int QW = 16,
  parameter int WW = 49
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [QW-1:0] en,
  input  logic [WW-1:0] rem_i,
  input  logic [WW-1:0] den_i,
  input  logic          neg_i,
  input  logic          ovf_i,
  input  logic          zero_i,
  output logic [QW-1:0] q_o,
  output logic          neg_o,
  output logic          ovf_o,
  output logic          zero_o
);
  logic [WW-1:0] rem_c  [QW+1];
  logic [WW-1:0] den_c  [QW+1];
  logic [QW-1:0] q_c    [QW+1];
  logic          neg_c  [QW+1];
  logic          ovf_c  [QW+1];
  logic          zero_c [QW+1];

  assign rem_c[0]  = rem_i;
  assign den_c[0]  = den_i;
  assign q_c[0]    = '0;
  assign neg_c[0]  = neg_i;
  assign ovf_c[0]  = ovf_i;
  assign zero_c[0] = zero_i;

  // stage j resolves quotient bit QW-1-j, most significant first
  generate
    for (genvar j = 0; j < QW; j++) begin : g_stage
      eq_div_stage #(.WW(WW), .QW(QW), .BIT(QW-1-j)) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en[j]),
        .rem_i  (rem_c[j]),
        .den_i  (den_c[j]),
        .q_i    (q_c[j]),
        .neg_i  (neg_c[j]),
        .ovf_i  (ovf_c[j]),
        .zero_i (zero_c[j]),
        .rem_o  (rem_c[j+1]),
        .den_o  (den_c[j+1]),
        .q_o    (q_c[j+1]),
        .neg_o  (neg_c[j+1]),
        .ovf_o  (ovf_c[j+1]),
        .zero_o (zero_c[j+1])
      );
    end
  endgenerate

  logic unused_tail;
  assign unused_tail = ^{rem_c[QW], den_c[QW]};

  assign q_o    = q_c[QW];
  assign neg_o  = neg_c[QW];
  assign ovf_o  = ovf_c[QW];
  assign zero_o = zero_c[QW];
endmodule

// File: rtl/freq_equalizer.sv
`timescale 1ns/1ps
module freq_equalizer
  import eq_pkg::*;
#(
  parameter int       DW   = 16,
  parameter int       FW   = 8,
  parameter eq_mode_e MODE = EQ_MMSE,
  localparam int QW   = DW,
  localparam int DENW = 2*DW + 1,
  localparam int WW   = DENW + QW,
  localparam int LAT  = QW + 3,
  localparam int CW   = $clog2(LAT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] data_re,
  input  logic signed [DW-1:0] data_im,
  input  logic signed [DW-1:0] est_re,
  input  logic signed [DW-1:0] est_im,
  input  logic        [DW-1:0] noise_var,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im,
  output logic                 div_zero
);
  logic rst_n_s;

  eq_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  logic [LAT:0] vld;

  eq_valid_pipe #(.LAT(LAT)) u_vld (
    .clk   (clk),
    .rst_n (rst_n_s),
    .vin   (in_valid),
    .vld   (vld)
  );

  logic [WW-1:0] rem_re, rem_im, den_w;
  logic          neg_re, neg_im, ovf_re, ovf_im, den_zero;

  eq_front #(.DW(DW), .FW(FW), .MODE(MODE)) u_front (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .en1       (vld[0]),
    .en2       (vld[1]),
    .data_re   (data_re),
    .data_im   (data_im),
    .est_re    (est_re),
    .est_im    (est_im),
    .noise_var (noise_var),
    .rem_re    (rem_re),
    .rem_im    (rem_im),
    .den_w     (den_w),
    .neg_re    (neg_re),
    .neg_im    (neg_im),
    .ovf_re    (ovf_re),
    .ovf_im    (ovf_im),
    .den_zero  (den_zero)
  );

  logic [QW-1:0] q_re, q_im;
  logic          qneg_re, qneg_im, qovf_re, qovf_im, qzero_re, qzero_im;

  eq_divider #(.QW(QW), .WW(WW)) u_div_re (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .en     (vld[QW+1:2]),
    .rem_i  (rem_re),
    .den_i  (den_w),
    .neg_i  (neg_re),
    .ovf_i  (ovf_re),
    .zero_i (den_zero),
    .q_o    (q_re),
    .neg_o  (qneg_re),
    .ovf_o  (qovf_re),
    .zero_o (qzero_re)
  );

  eq_divider #(.QW(QW), .WW(WW)) u_div_im (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .en     (vld[QW+1:2]),
    .rem_i  (rem_im),
    .den_i  (den_w),
    .neg_i  (neg_im),
    .ovf_i  (ovf_im),
    .zero_i (den_zero),
    .q_o    (q_im),
    .neg_o  (qneg_im),
    .ovf_o  (qovf_im),
    .zero_o (qzero_im)
  );

  logic unused_zero_im;
  assign unused_zero_im = qzero_im;

  // ---------------- output stage: sign, saturation, zero-denominator ----------------
  localparam logic [DW:0] LIM_POS = {2'b00, {(DW-1){1'b1}}};
  localparam logic [DW:0] LIM_NEG = {2'b01, {(DW-1){1'b0}}};

  function automatic logic [DW-1:0] finish_lane(input logic [QW-1:0] q,
                                                input logic neg, input logic ovf,
                                                input logic zero);
    logic [DW:0] qx;
    logic [DW:0] nq;
    qx = {1'b0, q};
    nq = -qx;
    if (zero)                           return '0;
    else if (!neg && (ovf || qx > LIM_POS)) return LIM_POS[DW-1:0];
    else if (!neg)                      return qx[DW-1:0];
    else if (ovf || qx > LIM_NEG)       return LIM_NEG[DW-1:0];
    else                                return nq[DW-1:0];
  endfunction

  logic          out_en;
  logic [DW-1:0] ore_d, oim_d;
  logic          dz_d;

  always_comb begin
    out_en = vld[QW+2];
    ore_d  = finish_lane(q_re, qneg_re, qovf_re, qzero_re);
    oim_d  = finish_lane(q_im, qneg_im, qovf_im, qzero_re);
    dz_d   = out_en & qzero_re;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      out_re   <= '0;
      out_im   <= '0;
      div_zero <= 1'b0;
    end else begin
      div_zero <= dz_d;
      if (out_en) begin
        out_re <= ore_d;
        out_im <= oim_d;
      end
    end
  end

  assign out_valid = vld[LAT];

  // cycles since reset release, saturating at LAT
  logic [CW-1:0] since_rst_q, since_rst_d;

  always_comb begin
    since_rst_d = (since_rst_q == CW'(LAT)) ? since_rst_q : since_rst_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) since_rst_q <= '0;
    else          since_rst_q <= since_rst_d;
  end

  // R1: no result can emerge before the pipeline has been filled once
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n_s)
    (since_rst_q < CW'(LAT)) |-> !out_valid);

  // R7: the zero flag only accompanies a valid, zeroed result
  a_r7_zero_out: assert property (@(posedge clk) disable iff (!rst_n_s)
    div_zero |-> (out_valid && out_re == '0 && out_im == '0));

  // R5: a result needs an input LAT cycles back (checked one stage short of the output)
  a_r5_valid_source: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(out_valid) |-> $past(vld[QW+2]));
endmodule

// File: tb/test_freq_equalizer.sv
`timescale 1ns/1ps
module test_freq_equalizer;
  import eq_pkg::*;

  localparam int DW  = 8;
  localparam int FW  = 4;
  localparam int LAT = DW + 3;
  localparam int NMAX = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] d_re = '0, d_im = '0, h_re = '0, h_im = '0;
  logic        [DW-1:0] nv = '0;

  logic                 mm_valid, zf_valid, mm_dz, zf_dz;
  logic signed [DW-1:0] mm_re, mm_im, zf_re, zf_im;

  freq_equalizer #(.DW(DW), .FW(FW), .MODE(EQ_MMSE)) i_freq_equalizer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .data_re(d_re), .data_im(d_im), .est_re(h_re), .est_im(h_im), .noise_var(nv),
    .out_valid(mm_valid), .out_re(mm_re), .out_im(mm_im), .div_zero(mm_dz));

  freq_equalizer #(.DW(DW), .FW(FW), .MODE(EQ_ZF)) i_freq_equalizer_zf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .data_re(d_re), .data_im(d_im), .est_re(h_re), .est_im(h_im), .noise_var(nv),
    .out_valid(zf_valid), .out_re(zf_re), .out_im(zf_im), .div_zero(zf_dz));

  int total = 0, bad = 0, cyc = 0, sent = 0, got_mm = 0, got_zf = 0;
  int    sent_cyc [NMAX];
  int    e_re [2][NMAX];
  int    e_im [2][NMAX];
  bit    e_dz [2][NMAX];
  string e_tag[2][NMAX];

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  function automatic int lane(longint n, longint den, output bit sat);
    longint m, q;
    sat = 1'b0;
    if (den == 0) return 0;
    m = (n < 0 ? -n : n) * (64'd1 << FW);
    q = m / den;
    if (n >= 0) begin
      if (q > 127) begin sat = 1'b1; return 127; end
      return int'(q);
    end
    if (q > 128) begin sat = 1'b1; return -128; end
    return -int'(q);
  endfunction

  task automatic expect_one(int dr, int di, int hr, int hi, int nvv, bit mm,
                            output int ore, output int oim, output bit dz,
                            output string tag);
    longint nr, ni, den;
    bit s1, s2;
    nr  = longint'(dr) * hr + longint'(di) * hi;
    ni  = longint'(di) * hr - longint'(dr) * hi;
    den = longint'(hr) * hr + longint'(hi) * hi + (mm ? longint'(nvv) * (1 << FW) : 0);
    dz  = (den == 0);
    ore = lane(nr, den, s1);
    oim = lane(ni, den, s2);
    if (dz)            tag = "R7";
    else if (s1 || s2) tag = mm ? "R6 R4" : "R6 R2";
    else               tag = mm ? "R4" : "R2 R3";
  endtask

  task automatic check_side(bit k, bit v, int re, int im, bit dz);
    int ptr;
    ptr = k ? got_mm : got_zf;
    if (!v) begin
      if (dz) begin
        total++; bad++;
        $display("FAIL R7 inst=%0d div_zero without valid actual=1 expected=0", k);
      end
      return;
    end
    total++;
    if (ptr >= sent) begin
      bad++;
      $display("FAIL R5 inst=%0d unexpected output actual=%0d outputs expected=%0d", k, ptr + 1, sent);
      return;
    end
    if (re != e_re[k][ptr] || im != e_im[k][ptr] || dz != e_dz[k][ptr]) begin
      bad++;
      $display("FAIL %s inst=%0d idx=%0d actual=(%0d,%0d,dz=%0d) expected=(%0d,%0d,dz=%0d)",
               e_tag[k][ptr], k, ptr, re, im, dz, e_re[k][ptr], e_im[k][ptr], e_dz[k][ptr]);
    end
    total++;
    if (cyc != sent_cyc[ptr] + LAT) begin
      bad++;
      $display("FAIL R5 inst=%0d idx=%0d latency actual=%0d expected=%0d",
               k, ptr, cyc - sent_cyc[ptr], LAT);
    end
    if (k) got_mm++; else got_zf++;
  endtask

  // one cycle: sample outputs at the falling edge, then drive the next inputs
  task automatic step(bit v, int dr, int di, int hr, int hi, int nvv);
    @(negedge clk);
    cyc++;
    check_side(1'b1, mm_valid, int'(mm_re), int'(mm_im), mm_dz);
    check_side(1'b0, zf_valid, int'(zf_re), int'(zf_im), zf_dz);
    in_valid = v;
    if (v && sent < NMAX) begin
      d_re = DW'(dr); d_im = DW'(di); h_re = DW'(hr); h_im = DW'(hi); nv = DW'(nvv);
      sent_cyc[sent] = cyc;
      expect_one(dr, di, hr, hi, nvv, 1'b1, e_re[1][sent], e_im[1][sent], e_dz[1][sent], e_tag[1][sent]);
      expect_one(dr, di, hr, hi, nvv, 1'b0, e_re[0][sent], e_im[0][sent], e_dz[0][sent], e_tag[0][sent]);
      sent++;
    end else begin
      in_valid = 1'b0;
    end
  endtask

  task automatic reset_check(string when);
    total++;
    if (mm_valid || zf_valid || mm_dz || zf_dz || mm_re != 0 || mm_im != 0 || zf_re != 0 || zf_im != 0) begin
      bad++;
      $display("FAIL R1 %s actual=v%0d%0d dz%0d%0d re%0d im%0d expected=all zero",
               when, mm_valid, zf_valid, mm_dz, zf_dz, mm_re, mm_im);
    end
  endtask

  int pat_re [6] = '{127, -128, 5, -64, 0, 1};
  int pat_im [6] = '{127, -128, -3, 100, 0, 0};

  initial begin
    repeat (3) @(negedge clk);
    reset_check("during reset");
    rst_n = 1'b1;
    repeat (4) step(1'b0, 0, 0, 0, 0, 0);
    reset_check("after release");

    // wide sweep of estimates over the full signed range
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int p = 0; p < 6; p++) begin
          int nvv;
          nvv = ((sent % 5) == 0) ? 0 : ((sent * 37 + 11) % 256);
          step(1'b1, pat_re[p], pat_im[p], -128 + a * 17, -128 + b * 17, nvv);
          if ((sent % 7) == 0) step(1'b0, 0, 0, 0, 0, 0);
        end
      end
    end

    // tiny estimates: zero denominators and saturation
    for (int hr = -3; hr <= 3; hr++) begin
      for (int hi = -3; hi <= 3; hi++) begin
        for (int p = 0; p < 6; p++) begin
          int nvv;
          nvv = ((sent % 3) == 0) ? 0 : (sent % 4);
          step(1'b1, pat_re[p], pat_im[p], hr, hi, nvv);
        end
      end
    end

    // explicit corner cases
    step(1'b1, 50, -20, 0, 0, 0);     // R7 in both modes
    step(1'b1, 50, -20, 0, 0, 1);     // R7 in ZF only, R4 in MMSE
    step(1'b1, 16, 16, 16, 0, 0);     // exact unit estimate
    step(1'b1, 16, 16, 16, 0, 255);   // R3 same ZF output, R4 large variance

    repeat (LAT + 4) step(1'b0, 0, 0, 0, 0, 0);

    total++;
    if (got_mm != sent || got_zf != sent) begin
      bad++;
      $display("FAIL R5 output count actual=%0d/%0d expected=%0d", got_mm, got_zf, sent);
    end
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end
endmodule